// File: doc/BRIEF.md
# Snooping MESI Cache Coherence Controller

This block sits between one processor and a shared snooping bus and keeps a small direct-mapped write-back cache coherent with the caches of other processors. Every line carries one of four states: Invalid, Shared (clean, other copies may exist), Exclusive (clean, the only copy) and Modified (dirty, the only copy). Processor loads and stores that the local state allows complete locally. Otherwise the controller places a read, a read-for-ownership or a write-back on the bus and waits for the responder's acknowledge.

At the same time the controller watches transactions from other caches. When it holds the addressed line it drives a shared response for reads. When the line is dirty it drives a flush response with the line data, and it demotes or invalidates its own copy. The shared response that comes back during a read fill decides whether the line lands Exclusive or Shared. An Exclusive line can therefore be written without any bus traffic.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid: `bus_req` and `cpu_done` are low, a snooped access raises neither `snp_shared` nor `snp_flush`, and the first processor access to any address misses.
- R2: A read miss to a non-dirty index issues a bus read (`bus_cmd` = 1) for the requested address. On acknowledge the line becomes Exclusive if `bus_shared_in` is low and Shared if it is high. `cpu_rdata` returns `bus_rdata` and `cpu_done` pulses on the edge after the acknowledge.
- R3: A read that hits in Modified, Exclusive or Shared returns the line data with no bus transaction. `cpu_done` rises on the first edge that samples the request.
- R4: A write that hits an Exclusive or Modified line updates the data and leaves it Modified with no bus transaction, and it completes like a read hit.
- R5: A write that misses, or that hits a Shared line, issues a read-for-ownership (`bus_cmd` = 2) for that address. On acknowledge the line holds the written data in Modified.
- R6: A snooped read-for-ownership (`snp_cmd` = 2) that hits a valid line invalidates it. In the same cycle `snp_flush` is high with `snp_data` equal to the line data exactly when the line was Modified. `snp_shared` stays low.
- R7: A snooped read (`snp_cmd` = 1) that hits a valid line raises `snp_shared` in the same cycle and leaves the line Shared. If the line was Modified, `snp_flush` is also high with the line data.
- R8: A miss on an index that holds a Modified line first issues a write-back (`bus_cmd` = 3) with the victim's address and data, then the fill. A clean victim is replaced without a write-back.
- R9: A snoop has priority. A processor request in the same cycle as a snoop is evaluated only after the snoop has updated the state. A snoop that takes away the victim of a pending write-back cancels that write-back, and the request is re-evaluated.
- R10: `bus_req`, `bus_cmd` and `bus_addr` hold steady until acknowledge unless a snoop intervenes. A snooped write-back (`snp_cmd` = 3), or a snoop to a tag not present, leaves outputs and state unchanged.
- R11: `cpu_done` is a single-cycle pulse per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address; low IDX_W bits select the line |
| cpu_wdata | input | DATA_W | Store data |
| cpu_done | output | 1 | Request complete (one-cycle pulse) |
| cpu_rdata | output | DATA_W | Load data, valid with `cpu_done` |
| bus_req | output | 1 | Bus transaction pending |
| bus_cmd | output | 2 | 0 none, 1 read, 2 read-for-ownership, 3 write-back |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Write-back data |
| bus_ack | input | 1 | Responder completes the transaction this cycle |
| bus_rdata | input | DATA_W | Fill data, valid with `bus_ack` |
| bus_shared_in | input | 1 | Wired-OR shared line, sampled with `bus_ack` |
| snp_valid | input | 1 | Remote transaction to snoop this cycle |
| snp_cmd | input | 2 | Remote command, same encoding as `bus_cmd` |
| snp_addr | input | ADDR_W | Remote transaction address |
| snp_shared | output | 1 | This cache holds the snooped line (reads only) |
| snp_flush | output | 1 | This cache supplies dirty data |
| snp_data | output | DATA_W | Line data for the flush |

## Verification
Snoop responses are combinational, so the bench samples `snp_shared`, `snp_flush` and `snp_data` a moment after it drives a snoop, in the same cycle. A local hit raises `cpu_done` one edge after the request is presented. A plain fill takes two edges (request, then acknowledge), and a dirty eviction takes four (write-back, acknowledge, re-evaluation, fill). The bench counts edges while it waits for `cpu_done` and compares that count with these figures. It logs every bus transaction the responder acknowledges, so the absence of traffic is checked as well. Priority cases drive the snoop and the request on the same negedge and then check which transaction reaches the bus.

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LINES  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_shared_in,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_shared,
  output logic              snp_flush,
  output logic [DATA_W-1:0] snp_data
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  localparam logic [1:0] ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3;
  localparam logic [1:0] C_NONE = 2'd0, C_RD = 2'd1, C_RDX = 2'd2, C_WB = 2'd3;
  localparam logic [1:0] F_IDLE = 2'd0, F_WB = 2'd1, F_FILL = 2'd2;

  logic [1:0]        st_q  [LINES];
  logic [TAG_W-1:0]  tag_q [LINES];
  logic [DATA_W-1:0] dat_q [LINES];

  logic [1:0]        fsm_q, cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              done_q;

  wire [IDX_W-1:0] c_idx = cpu_addr[IDX_W-1:0];
  wire [TAG_W-1:0] c_tag = cpu_addr[ADDR_W-1:IDX_W];
  wire [IDX_W-1:0] s_idx = snp_addr[IDX_W-1:0];
  wire [TAG_W-1:0] s_tag = snp_addr[ADDR_W-1:IDX_W];
  wire [IDX_W-1:0] a_idx = addr_q[IDX_W-1:0];
  wire [TAG_W-1:0] a_tag = addr_q[ADDR_W-1:IDX_W];

  wire [1:0] c_st  = st_q[c_idx];
  wire [1:0] s_st  = st_q[s_idx];
  wire       c_hit = (c_st != ST_I) && (tag_q[c_idx] == c_tag);
  wire       s_hit = (s_st != ST_I) && (tag_q[s_idx] == s_tag);

  wire snp_req    = (snp_cmd == C_RD) || (snp_cmd == C_RDX);
  wire snp_act    = snp_valid && s_hit && snp_req;
  wire accept     = (fsm_q == F_IDLE) && cpu_req && !done_q && !snp_valid;
  wire local_ok   = c_hit && (!cpu_we || c_st == ST_M || c_st == ST_E);
  wire victim_hit = snp_act && (fsm_q == F_WB) && (s_idx == a_idx) && (s_tag == a_tag);
  wire fill_ack   = (fsm_q == F_FILL) && bus_ack;
  wire wb_ack     = (fsm_q == F_WB) && bus_ack && !victim_hit;

  assign snp_shared = snp_valid && s_hit && (snp_cmd == C_RD);
  assign snp_flush  = snp_act && (s_st == ST_M);
  assign snp_data   = dat_q[s_idx];

  assign bus_req   = (fsm_q != F_IDLE);
  assign bus_cmd   = bus_req ? cmd_q : C_NONE;
  assign bus_addr  = addr_q;
  assign bus_wdata = wdata_q;
  assign cpu_done  = done_q;
  assign cpu_rdata = rdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) st_q[i] <= ST_I;
    end else begin
      if (snp_act)
        st_q[s_idx] <= (snp_cmd == C_RD) ? ST_S : ST_I;
      if (accept && cpu_we && local_ok)
        st_q[c_idx] <= ST_M;
      if (wb_ack)
        st_q[a_idx] <= ST_I;
      if (fill_ack)
        st_q[a_idx] <= (cmd_q == C_RDX) ? ST_M : (bus_shared_in ? ST_S : ST_E);
    end
  end

  always_ff @(posedge clk) begin
    if (accept && cpu_we && local_ok)
      dat_q[c_idx] <= cpu_wdata;
    if (fill_ack) begin
      tag_q[a_idx] <= a_tag;
      dat_q[a_idx] <= (cmd_q == C_RDX) ? wdata_q : bus_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm_q   <= F_IDLE;
      cmd_q   <= C_NONE;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (fsm_q)
        F_IDLE: if (accept) begin
          if (local_ok) begin
            done_q  <= 1'b1;
            rdata_q <= cpu_we ? cpu_wdata : dat_q[c_idx];
          end else if (!c_hit && c_st == ST_M) begin
            fsm_q   <= F_WB;
            cmd_q   <= C_WB;
            addr_q  <= {tag_q[c_idx], c_idx};
            wdata_q <= dat_q[c_idx];
          end else begin
            fsm_q   <= F_FILL;
            cmd_q   <= cpu_we ? C_RDX : C_RD;
            addr_q  <= cpu_addr;
            wdata_q <= cpu_wdata;
          end
        end
        F_WB: if (victim_hit || bus_ack) fsm_q <= F_IDLE;
        F_FILL: if (bus_ack) begin
          fsm_q   <= F_IDLE;
          done_q  <= 1'b1;
          rdata_q <= (cmd_q == C_RDX) ? wdata_q : bus_rdata;
        end
        default: fsm_q <= F_IDLE;
      endcase
    end
  end

  AST_RD_FILL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    fill_ack && cmd_q == C_RD && !bus_shared_in |=> st_q[$past(a_idx)] == ST_E && cpu_done); // R2
  AST_E_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    accept && cpu_we && c_hit && c_st == ST_E |=> !bus_req && cpu_done); // R4
  AST_RDX_FILL_MOD: assert property (@(posedge clk) disable iff (!rst_n)
    fill_ack && cmd_q == C_RDX |=> st_q[$past(a_idx)] == ST_M); // R5
  AST_SNP_RDX_INVAL: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && snp_cmd == C_RDX && s_hit && !(fill_ack && a_idx == s_idx)
    |=> st_q[$past(s_idx)] == ST_I); // R6
  AST_SNP_RD_SHARE: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && snp_cmd == C_RD && s_hit && !(fill_ack && a_idx == s_idx)
    |=> st_q[$past(s_idx)] == ST_S); // R7
  AST_SNOOP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && fsm_q == F_IDLE |=> !cpu_done); // R9
  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack && !snp_valid |=> bus_req && $stable(bus_addr) && $stable(bus_cmd)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done); // R11
endmodule

// File: tb/test_mesi_snoop_ctrl.sv
`timescale 1ns/1ps
module test_mesi_snoop_ctrl;
  logic        clk = 0, rst_n = 0;
  logic        cpu_req = 0, cpu_we = 0;
  logic [15:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_done;
  logic [31:0] cpu_rdata;
  logic        bus_req;
  logic [1:0]  bus_cmd;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_ack = 0, bus_shared_in = 0;
  logic [31:0] bus_rdata = '0;
  logic        snp_valid = 0;
  logic [1:0]  snp_cmd = '0;
  logic [15:0] snp_addr = '0;
  logic        snp_shared, snp_flush;
  logic [31:0] snp_data;

  int nchk = 0, nfail = 0, cycles = 0;
  logic [31:0] mem [256];
  logic        stall = 0, shared_mode = 0;
  int          ntx = 0;
  logic [1:0]  log_cmd  [8];
  logic [15:0] log_addr [8];
  logic [31:0] log_data [8];

  always #2.5 clk = ~clk;

  mesi_snoop_ctrl i_mesi_snoop_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .bus_shared_in(bus_shared_in),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .snp_shared(snp_shared), .snp_flush(snp_flush), .snp_data(snp_data));

  function automatic logic [31:0] memval(input logic [15:0] a);
    return 32'hC0DE0000 ^ (32'(a) * 32'h101);
  endfunction

  always @(negedge clk) begin
    if (bus_ack) bus_ack = 0;
    else if (bus_req && !stall) begin
      bus_ack = 1;
      bus_rdata = mem[bus_addr[7:0]];
      bus_shared_in = shared_mode;
      if (ntx < 8) begin
        log_cmd[ntx] = bus_cmd; log_addr[ntx] = bus_addr; log_data[ntx] = bus_wdata;
      end
      ntx++;
      if (bus_cmd == 2'd3) mem[bus_addr[7:0]] = bus_wdata;
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cpu_op(input logic we, input logic [15:0] a, input logic [31:0] wd,
                        output logic [31:0] rd, output int cyc);
    @(negedge clk);
    ntx = 0; cpu_we = we; cpu_addr = a; cpu_wdata = wd; cpu_req = 1; cyc = 0;
    do begin @(negedge clk); cyc++; end while (!cpu_done && cyc < 200);
    rd = cpu_rdata;
    cpu_req = 0;
    @(negedge clk);
    chk("R11", "done pulse", cpu_done, 0);
  endtask

  task automatic snoop(input logic [1:0] c, input logic [15:0] a, input logic esh,
                       input logic efl, input logic [31:0] ed, input string req);
    @(negedge clk);
    snp_valid = 1; snp_cmd = c; snp_addr = a;
    #1;
    chk(req, "snp_shared", snp_shared, esh);
    chk(req, "snp_flush", snp_flush, efl);
    if (efl) chk(req, "snp_data", snp_data, ed);
    @(negedge clk);
    snp_valid = 0;
  endtask

  task automatic t_reset;
    chk("R1", "bus_req", bus_req, 0);
    chk("R1", "cpu_done", cpu_done, 0);
    snoop(2'd1, 16'h0011, 0, 0, 0, "R1");
  endtask

  task automatic t_exclusive;
    logic [31:0] rd; int cyc;
    shared_mode = 0;
    cpu_op(0, 16'h0011, 0, rd, cyc);
    chk("R1", "first access misses", ntx, 1);
    chk("R2", "cmd", log_cmd[0], 1);
    chk("R2", "addr", log_addr[0], 16'h0011);
    chk("R2", "rdata", rd, memval(16'h0011));
    chk("R2", "latency", cyc, 2);
    cpu_op(0, 16'h0011, 0, rd, cyc);
    chk("R3", "hit E no tx", ntx, 0);
    chk("R3", "hit latency", cyc, 1);
    chk("R3", "hit data", rd, memval(16'h0011));
    cpu_op(1, 16'h0011, 32'hAAAA0001, rd, cyc);
    chk("R4", "write E no tx", ntx, 0);
    chk("R4", "write latency", cyc, 1);
    cpu_op(0, 16'h0011, 0, rd, cyc);
    chk("R3", "hit M data", rd, 32'hAAAA0001);
    chk("R3", "hit M no tx", ntx, 0);
    snoop(2'd1, 16'h0011, 1, 1, 32'hAAAA0001, "R7");
    snoop(2'd1, 16'h0011, 1, 0, 0, "R7");
    cpu_op(0, 16'h0011, 0, rd, cyc);
    chk("R3", "hit S no tx", ntx, 0);
    chk("R3", "hit S data", rd, 32'hAAAA0001);
  endtask

  task automatic t_shared_fill;
    logic [31:0] rd; int cyc;
    shared_mode = 1;
    cpu_op(0, 16'h0022, 0, rd, cyc);
    shared_mode = 0;
    chk("R2", "shared fill data", rd, memval(16'h0022));
    snoop(2'd1, 16'h0022, 1, 0, 0, "R2");
    cpu_op(1, 16'h0022, 32'hBBBB0002, rd, cyc);
    chk("R5", "upgrade tx count", ntx, 1);
    chk("R5", "upgrade cmd", log_cmd[0], 2);
    chk("R5", "upgrade addr", log_addr[0], 16'h0022);
    snoop(2'd1, 16'h0022, 1, 1, 32'hBBBB0002, "R5");
  endtask

  task automatic t_snoop_rdx;
    logic [31:0] rd; int cyc;
    cpu_op(0, 16'h0033, 0, rd, cyc);
    snoop(2'd2, 16'h0033, 0, 0, 0, "R6");
    cpu_op(0, 16'h0033, 0, rd, cyc);
    chk("R6", "miss after inval", ntx, 1);
    cpu_op(1, 16'h0044, 32'hCCCC0004, rd, cyc);
    chk("R5", "write miss cmd", log_cmd[0], 2);
    chk("R5", "write miss latency", cyc, 2);
    snoop(2'd2, 16'h0044, 0, 1, 32'hCCCC0004, "R6");
    cpu_op(0, 16'h0044, 0, rd, cyc);
    chk("R6", "M inval miss", ntx, 1);
    chk("R6", "M inval cmd", log_cmd[0], 1);
  endtask

  task automatic t_evict;
    logic [31:0] rd; int cyc;
    cpu_op(1, 16'h0015, 32'hDDDD0005, rd, cyc);
    cpu_op(0, 16'h0025, 0, rd, cyc);
    chk("R8", "dirty evict tx", ntx, 2);
    chk("R8", "wb cmd", log_cmd[0], 3);
    chk("R8", "wb addr", log_addr[0], 16'h0015);
    chk("R8", "wb data", log_data[0], 32'hDDDD0005);
    chk("R8", "fill cmd", log_cmd[1], 1);
    chk("R8", "fill addr", log_addr[1], 16'h0025);
    chk("R8", "latency", cyc, 4);
    chk("R8", "memory updated", mem[8'h15], 32'hDDDD0005);
    chk("R8", "fill data", rd, memval(16'h0025));
    cpu_op(0, 16'h0015, 0, rd, cyc);
    chk("R8", "clean evict silent", ntx, 1);
    chk("R8", "clean evict cmd", log_cmd[0], 1);
    chk("R8", "refetch data", rd, 32'hDDDD0005);
  endtask

  task automatic t_ignore;
    logic [31:0] rd; int cyc;
    cpu_op(1, 16'h0036, 32'hEEEE0006, rd, cyc);
    snoop(2'd3, 16'h0036, 0, 0, 0, "R10");
    snoop(2'd1, 16'h0046, 0, 0, 0, "R10");
    cpu_op(1, 16'h0036, 32'hEEEE0007, rd, cyc);
    chk("R10", "line still M", ntx, 0);
    chk("R10", "hit latency", cyc, 1);
  endtask

  task automatic t_priority;
    logic [31:0] rd; int cyc;
    cpu_op(0, 16'h0017, 0, rd, cyc);
    @(negedge clk);
    ntx = 0;
    cpu_we = 1; cpu_addr = 16'h0017; cpu_wdata = 32'hF0F00017; cpu_req = 1;
    snp_valid = 1; snp_cmd = 2'd2; snp_addr = 16'h0017;
    #1;
    chk("R9", "clean line no flush", snp_flush, 0);
    @(negedge clk);
    snp_valid = 0;
    cyc = 0;
    while (!cpu_done && cyc < 200) begin @(negedge clk); cyc++; end
    cpu_req = 0;
    chk("R9", "write after snoop uses bus", ntx, 1);
    chk("R9", "cmd is rdx", log_cmd[0], 2);
    @(negedge clk);
    snoop(2'd1, 16'h0017, 1, 1, 32'hF0F00017, "R9");
  endtask

  task automatic t_wb_cancel;
    logic [31:0] rd; int cyc;
    cpu_op(1, 16'h0013, 32'h13131313, rd, cyc);
    stall = 1;
    @(negedge clk);
    ntx = 0;
    cpu_we = 0; cpu_addr = 16'h0023; cpu_req = 1;
    @(negedge clk);
    chk("R8", "wb pending", bus_req, 1);
    chk("R8", "wb cmd", bus_cmd, 3);
    chk("R8", "wb addr", bus_addr, 16'h0013);
    chk("R8", "wb data", bus_wdata, 32'h13131313);
    @(negedge clk);
    chk("R10", "held cmd", bus_cmd, 3);
    chk("R10", "held addr", bus_addr, 16'h0013);
    snp_valid = 1; snp_cmd = 2'd2; snp_addr = 16'h0013;
    #1;
    chk("R6", "victim flush", snp_flush, 1);
    chk("R6", "victim data", snp_data, 32'h13131313);
    @(negedge clk);
    snp_valid = 0;
    chk("R9", "wb cancelled", bus_req, 0);
    stall = 0;
    cyc = 0;
    while (!cpu_done && cyc < 200) begin @(negedge clk); cyc++; end
    rd = cpu_rdata;
    cpu_req = 0;
    chk("R9", "only fill on bus", ntx, 1);
    chk("R9", "fill cmd", log_cmd[0], 1);
    chk("R9", "fill addr", log_addr[0], 16'h0023);
    chk("R9", "no stale writeback", mem[8'h13], memval(16'h0013));
    chk("R9", "fill data", rd, memval(16'h0023));
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = memval(16'(i));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_exclusive();
    t_shared_fill();
    t_snoop_rdx();
    t_evict();
    t_ignore();
    t_priority();
    t_wb_cancel();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual %0d expected <= 100000 cycles", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
    end
  end
endmodule